// File: doc/BRIEF.md
# Paged Flash Read Host Controller

This block is the host side of a serial link to a paged flash device. It runs one read at a time. A request names the read kind, a page number, a start byte within the page or buffer, and how many bytes to fetch. The block lowers chip select and sends the command header most significant bit first. The header length depends on the kind: 64 bits for a main page read and 40 bits for a buffer read. The block then clocks in exactly the requested number of data bytes and hands each byte to a consumer over a valid/ready pair.

The serial clock comes from the system clock through a divider. Each serial clock half period lasts `CLK_HALF` system cycles. The clock idles low. The block changes its serial output on the falling edge and samples the returned data at the end of the high half. If the consumer holds off a byte, the serial clock stops low until the consumer takes it. The block does not model the device's wrap at the page or buffer end. It captures whatever arrives.

Top module: `flashReadHost`

## Requirements
- R1: A request with kind 0 (main page) sends a 64-bit header on `flashMosi`. The fields are, in order: opcode 0x52, one zero bit, the 13-bit page number, the 10-bit start byte, and 32 zero bits.
- R2: A request with kind 1 or 2 (buffer one or two) sends a 40-bit header. The fields are, in order: opcode 0x54 (kind 1) or 0x56 (kind 2), 14 zero bits, the 10-bit start byte, and 8 zero bits. The page input is ignored.
- R3: Every bit is sent and received most significant bit first. Each received byte appears on `dataByte` with the first bit sampled in bit 7.
- R4: `flashCsN` stays low from the first header bit to the last requested data bit. Over that window `flashSck` makes exactly header length plus 8 × count rising edges. `flashSck` is low whenever `flashCsN` is high.
- R5: A byte count larger than 528 is allowed. The block delivers every requested byte in the order the device sends it.
- R6: Between the rise of `flashCsN` and its next fall there are at least 4 × `CLK_HALF` system cycles, which is two serial clock periods.
- R7: `busy` is high from the cycle after a request is accepted until the transaction ends. A request presented while `busy` is high starts no transaction.
- R8: While `dataValid` is high and `dataReady` is low, the byte and valid hold steady and `flashSck` stays low with no edges.
- R9: A request with count 0 or kind 3 is ignored. `busy` stays low and `flashCsN` stays high.
- R10: After reset, `flashCsN` is high, `flashSck` is low, and `busy` and `dataValid` are low.
- R11: `flashMosi` changes only while `flashSck` is low. It never changes during a high half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when `busy` is low |
| reqType | input | 2 | 0 main page, 1 buffer one, 2 buffer two, 3 ignored |
| reqPage | input | 13 | Page number 0..8191 |
| reqByte | input | 10 | Start byte 0..527 |
| reqCount | input | 16 | Number of data bytes to read |
| busy | output | 1 | Transaction in progress |
| flashCsN | output | 1 | Chip select, active low |
| flashSck | output | 1 | Serial clock, idles low |
| flashMosi | output | 1 | Serial data to the device |
| flashMiso | input | 1 | Serial data from the device |
| dataValid | output | 1 | Received byte is available |
| dataReady | input | 1 | Consumer accepts the byte |
| dataByte | output | 8 | Received byte |

## Verification
The hardest cases to reach are a stall that lands on the very last byte, where chip select must already be high while the byte waits, and a read that runs past the 528-byte wrap. A behavioural device model in the bench decodes the header it receives and returns bytes derived from that header, so a framing error shows up as wrong data. The consumer's ready signal is random with a fixed seed, so stalls land on every byte position, including the last. One directed read starts at byte 520 with a count of 600 to cross the wrap.

// File: rtl/flashRdPkg.sv
package flashRdPkg;
  localparam int OPCODE_W   = 8;
  localparam int ADDR_W     = 24;
  localparam int MAIN_DUMMY = 32;
  localparam int BUF_DUMMY  = 8;
  localparam int GAP_HALVES = 4;

  localparam logic [7:0] OP_MAIN = 8'h52;
  localparam logic [7:0] OP_BUF1 = 8'h54;
  localparam logic [7:0] OP_BUF2 = 8'h56;

  typedef enum logic [1:0] {
    KIND_MAIN = 2'd0,
    KIND_BUF1 = 2'd1,
    KIND_BUF2 = 2'd2,
    KIND_NONE = 2'd3
  } rdKind_e;

  typedef struct packed {
    logic load;
    logic divClr;
    logic bitEnd;
    logic gapStep;
    logic popByte;
  } ctlStrobe_t;
endpackage

// File: rtl/flashRdPath.sv
module flashRdPath
  import flashRdPkg::*;
#(
  parameter int PAGE_BITS  = 13,
  parameter int BYTE_BITS  = 10,
  parameter int COUNT_BITS = 16,
  parameter int CLK_HALF   = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobe_t            strobe,
  input  logic [1:0]            reqType,
  input  logic [PAGE_BITS-1:0]  reqPage,
  input  logic [BYTE_BITS-1:0]  reqByte,
  input  logic [COUNT_BITS-1:0] reqCount,
  input  logic                  miso,
  output logic                  mosi,
  output logic [7:0]            rxByte,
  output logic                  divDone,
  output logic                  hdrLast,
  output logic                  byteLast,
  output logic                  lastByte,
  output logic                  gapDone
);
  localparam int HDR_W    = OPCODE_W + ADDR_W + MAIN_DUMMY;
  localparam int BUF_LEN  = OPCODE_W + ADDR_W + BUF_DUMMY;
  localparam int RSV_W    = ADDR_W - PAGE_BITS - BYTE_BITS;
  localparam int BUF_PRE  = ADDR_W - BYTE_BITS;
  localparam int BUF_TAIL = HDR_W - BUF_LEN + BUF_DUMMY;
  localparam int CNT_W    = $clog2(HDR_W + 1);
  localparam int DIV_W    = $clog2(CLK_HALF + 1);

  logic [HDR_W-1:0]      txShift;
  logic [HDR_W-1:0]      mainHdr, bufHdr;
  logic [7:0]            bufOp;
  logic [CNT_W-1:0]      bitCnt, hdrLen;
  logic                  dataPhase;
  logic [DIV_W-1:0]      divCnt;
  logic [COUNT_BITS-1:0] bytesLeft;

  assign bufOp   = (reqType == KIND_BUF2) ? OP_BUF2 : OP_BUF1;
  assign mainHdr = {OP_MAIN, {RSV_W{1'b0}}, reqPage, reqByte, {MAIN_DUMMY{1'b0}}};
  assign bufHdr  = {bufOp, {BUF_PRE{1'b0}}, reqByte, {BUF_TAIL{1'b0}}};

  assign divDone  = (divCnt == DIV_W'(CLK_HALF - 1));
  assign hdrLast  = !dataPhase && (bitCnt == hdrLen - 1'b1);
  assign byteLast = dataPhase && (bitCnt == CNT_W'(7));
  assign lastByte = (bytesLeft == COUNT_BITS'(1));
  assign gapDone  = divDone && (bitCnt == CNT_W'(GAP_HALVES - 1));
  assign mosi     = txShift[HDR_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift   <= '0;
      rxByte    <= '0;
      bitCnt    <= '0;
      hdrLen    <= '0;
      dataPhase <= 1'b0;
      divCnt    <= '0;
      bytesLeft <= '0;
    end else begin
      divCnt <= (strobe.divClr || divDone) ? '0 : divCnt + 1'b1;
      if (strobe.load) begin
        txShift   <= (reqType == KIND_MAIN) ? mainHdr : bufHdr;
        hdrLen    <= (reqType == KIND_MAIN) ? CNT_W'(HDR_W) : CNT_W'(BUF_LEN);
        dataPhase <= 1'b0;
        bitCnt    <= '0;
        bytesLeft <= reqCount;
      end
      if (strobe.bitEnd) begin
        txShift <= {txShift[HDR_W-2:0], 1'b0};
        if (dataPhase) rxByte <= {rxByte[6:0], miso};
        if (hdrLast) begin
          dataPhase <= 1'b1;
          bitCnt    <= '0;
        end else if (byteLast) begin
          bitCnt <= '0;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
      if (strobe.gapStep) bitCnt <= bitCnt + 1'b1;
      if (strobe.popByte) bytesLeft <= bytesLeft - 1'b1;
    end
  end
endmodule

// File: rtl/flashRdCtl.sv
module flashRdCtl
  import flashRdPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqOk,
  input  logic       dataReady,
  input  logic       divDone,
  input  logic       hdrLast,
  input  logic       byteLast,
  input  logic       lastByte,
  input  logic       gapDone,
  output ctlStrobe_t strobe,
  output logic       busy,
  output logic       csN,
  output logic       sck,
  output logic       dataValid
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOW, ST_HIGH, ST_HOLD, ST_GAP
  } ctlState_e;

  ctlState_e state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        strobe.divClr = 1'b1;
        if (reqValid && reqOk) begin
          strobe.load = 1'b1;
          stateNext   = ST_LOW;
        end
      end
      ST_LOW: if (divDone) stateNext = ST_HIGH;
      ST_HIGH: begin
        if (divDone) begin
          strobe.bitEnd = 1'b1;
          stateNext     = byteLast ? ST_HOLD : ST_LOW;
        end
      end
      ST_HOLD: begin
        strobe.divClr = 1'b1;
        if (dataReady) begin
          strobe.popByte = 1'b1;
          stateNext      = lastByte ? ST_GAP : ST_LOW;
        end
      end
      ST_GAP: begin
        if (divDone) begin
          strobe.gapStep = 1'b1;
          if (gapDone) stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // hdrLast steers the datapath only; control needs no header knowledge
  logic unusedHdr;
  assign unusedHdr = hdrLast;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      csN   <= 1'b1;
      sck   <= 1'b0;
    end else begin
      state <= stateNext;
      sck   <= (stateNext == ST_HIGH);
      csN   <= !((stateNext == ST_LOW) || (stateNext == ST_HIGH) ||
                 ((stateNext == ST_HOLD) && !lastByte));
    end
  end

  assign busy      = (state != ST_IDLE);
  assign dataValid = (state == ST_HOLD);
endmodule

// File: rtl/flashReadHost.sv
module flashReadHost
  import flashRdPkg::*;
#(
  parameter int PAGE_BITS  = 13,
  parameter int BYTE_BITS  = 10,
  parameter int COUNT_BITS = 16,
  parameter int CLK_HALF   = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [1:0]            reqType,
  input  logic [PAGE_BITS-1:0]  reqPage,
  input  logic [BYTE_BITS-1:0]  reqByte,
  input  logic [COUNT_BITS-1:0] reqCount,
  output logic                  busy,
  output logic                  flashCsN,
  output logic                  flashSck,
  output logic                  flashMosi,
  input  logic                  flashMiso,
  output logic                  dataValid,
  input  logic                  dataReady,
  output logic [7:0]            dataByte
);
  ctlStrobe_t strobe;
  logic divDone, hdrLast, byteLast, lastByte, gapDone, reqOk;

  assign reqOk = (reqCount != '0) && (reqType != KIND_NONE);

  flashRdCtl uCtl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOk(reqOk),
    .dataReady(dataReady), .divDone(divDone), .hdrLast(hdrLast),
    .byteLast(byteLast), .lastByte(lastByte), .gapDone(gapDone),
    .strobe(strobe), .busy(busy), .csN(flashCsN), .sck(flashSck),
    .dataValid(dataValid)
  );

  flashRdPath #(
    .PAGE_BITS(PAGE_BITS), .BYTE_BITS(BYTE_BITS),
    .COUNT_BITS(COUNT_BITS), .CLK_HALF(CLK_HALF)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqType(reqType),
    .reqPage(reqPage), .reqByte(reqByte), .reqCount(reqCount),
    .miso(flashMiso), .mosi(flashMosi), .rxByte(dataByte),
    .divDone(divDone), .hdrLast(hdrLast), .byteLast(byteLast),
    .lastByte(lastByte), .gapDone(gapDone)
  );
endmodule

// File: rtl/flashReadHostChk.sv
module flashReadHostChk #(
  parameter int CLK_HALF = 2
) (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       flashCsN,
  input logic       flashSck,
  input logic       flashMosi,
  input logic       dataValid,
  input logic       dataReady,
  input logic [7:0] dataByte
);
  localparam int GAP_MIN = 4 * CLK_HALF;
  logic [15:0] csHighCnt;

  always_ff @(posedge clk) begin
    if (!rstN) csHighCnt <= 16'(GAP_MIN);
    else if (!flashCsN) csHighCnt <= '0;
    else if (csHighCnt != 16'hffff) csHighCnt <= csHighCnt + 1'b1;
  end

  assert_cs_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> flashCsN);
  assert_sck_gated_R4: assert property (@(posedge clk) disable iff (!rstN)
    flashCsN |-> !flashSck);
  assert_stall_sck_R8: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && !dataReady) |=> !flashSck && dataValid && $stable(dataByte));
  assert_mosi_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (flashSck && $past(flashSck)) |-> $stable(flashMosi));
  assert_cs_gap_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flashCsN) |-> (csHighCnt >= 16'(GAP_MIN)));
endmodule

bind flashReadHost flashReadHostChk #(.CLK_HALF(CLK_HALF)) uChk (
  .clk(clk), .rstN(rstN), .busy(busy), .flashCsN(flashCsN),
  .flashSck(flashSck), .flashMosi(flashMosi), .dataValid(dataValid),
  .dataReady(dataReady), .dataByte(dataByte)
);

// File: tb/flashReadHost_test.sv
module flashReadHost_test;
  localparam int HALF = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqType = '0;
  logic [12:0] reqPage = '0;
  logic [9:0] reqByte = '0;
  logic [15:0] reqCount = '0;
  logic busy, flashCsN, flashSck, flashMosi, dataValid;
  logic flashMiso = 1'b0;
  logic dataReady = 1'b0;
  logic [7:0] dataByte;

  int checks = 0, fails = 0;
  int readyPct = 100;

  // device model state
  logic [63:0] cmd;
  int riseCnt, csFalls, lastRises, minGap, gapRun;
  logic csPrev = 1'b1, sckPrev = 1'b0, mosiPrev = 1'b0, stallPrev = 1'b0;
  int stallEdges = 0, mosiBad = 0;
  logic [7:0] rxBuf [0:1023];
  int rxN;

  always #2.5 clk = ~clk;

  flashReadHost #(.CLK_HALF(HALF)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqType(reqType),
    .reqPage(reqPage), .reqByte(reqByte), .reqCount(reqCount),
    .busy(busy), .flashCsN(flashCsN), .flashSck(flashSck),
    .flashMosi(flashMosi), .flashMiso(flashMiso), .dataValid(dataValid),
    .dataReady(dataReady), .dataByte(dataByte)
  );

  function automatic logic [7:0] devByte(logic [7:0] op, logic [12:0] pg,
                                         logic [9:0] start, int n);
    int a;
    a = (int'(start) + n) % 528;
    return 8'((a * 5) + (int'(pg) * 3) + int'(op));
  endfunction

  function automatic logic [7:0] opOf(logic [1:0] k);
    return (k == 2'd0) ? 8'h52 : (k == 2'd1) ? 8'h54 : 8'h56;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // device model and monitors, sampled away from the active edge
  always @(negedge clk) begin
    if (!rstN) begin
      riseCnt = 0; csFalls = 0; lastRises = 0; minGap = 1000000; gapRun = 1000000;
    end else begin
      if (csPrev && !flashCsN) begin
        csFalls++; riseCnt = 0; cmd = '0;
        if (gapRun < minGap) minGap = gapRun;
      end
      if (!csPrev && flashCsN) begin
        lastRises = riseCnt; gapRun = 0;
      end
      if (flashCsN && gapRun < 1000000) gapRun++;
      if (stallPrev && (flashSck != sckPrev)) stallEdges++;
      if (flashSck && sckPrev && (flashMosi != mosiPrev)) mosiBad++;
      if (!flashCsN && flashSck && !sckPrev) begin
        if (riseCnt < 64) cmd[63 - riseCnt] = flashMosi;
        riseCnt++;
      end
      if (!flashCsN && !flashSck && sckPrev) begin
        int hl, idx;
        logic [7:0] b;
        hl = (cmd[63:56] == 8'h52) ? 64 : 40;
        if (riseCnt >= hl) begin
          idx = riseCnt - hl;
          b = devByte(cmd[63:56], (hl == 64) ? cmd[54:42] : 13'd0, cmd[41:32], idx / 8);
          flashMiso = b[7 - (idx % 8)];
        end
      end
      // consumer
      dataReady = ($urandom_range(99) < readyPct);
      if (dataValid && dataReady && rxN < 1024) begin
        rxBuf[rxN] = dataByte; rxN++;
      end
      stallPrev = dataValid && !dataReady;
      csPrev = flashCsN; sckPrev = flashSck; mosiPrev = flashMosi;
    end
  end

  task automatic doRead(logic [1:0] k, logic [12:0] pg, logic [9:0] st,
                        int cnt, bit poke);
    int fallsBefore, hl, badBytes;
    logic [63:0] expHdr;
    @(negedge clk);
    while (busy) @(negedge clk);
    fallsBefore = csFalls;
    rxN = 0; stallEdges = 0; mosiBad = 0;
    reqValid = 1'b1; reqType = k; reqPage = pg; reqByte = st; reqCount = 16'(cnt);
    @(negedge clk);
    reqValid = 1'b0;
    check(busy == 1'b1, "R7 busy after accept", busy, 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      reqValid = 1'b1; reqType = 2'd0; reqPage = 13'h1; reqByte = 10'd3; reqCount = 16'd2;
      repeat (3) @(negedge clk);
      reqValid = 1'b0;
    end
    while (busy) @(negedge clk);
    hl = (k == 2'd0) ? 64 : 40;
    if (k == 2'd0) begin
      expHdr = {8'h52, 1'b0, pg, st, 32'h0};
      check(cmd == expHdr, "R1 main header", cmd, expHdr);
    end else begin
      expHdr = {opOf(k), 14'h0, st, 8'h0, 24'h0};
      check(cmd[63:24] == expHdr[63:24], "R2 buffer header", cmd[63:24], expHdr[63:24]);
    end
    check(csFalls == fallsBefore + 1, "R7 one transaction per request", csFalls, fallsBefore + 1);
    check(lastRises == hl + 8 * cnt, "R4 clock edges under chip select", lastRises, hl + 8 * cnt);
    check(rxN == cnt, "R5 byte count delivered", rxN, cnt);
    badBytes = 0;
    for (int i = 0; i < cnt && i < rxN; i++)
      if (rxBuf[i] != devByte(opOf(k), (k == 2'd0) ? pg : 13'd0, st, i)) begin
        if (badBytes == 0)
          check(1'b0, "R3 received byte", rxBuf[i], devByte(opOf(k), (k == 2'd0) ? pg : 13'd0, st, i));
        badBytes++;
      end
    if (badBytes == 0) check(1'b1, "R3 received bytes", 0, 0);
    check(stallEdges == 0, "R8 sck held during stall", stallEdges, 0);
    check(mosiBad == 0, "R11 mosi steady in high half", mosiBad, 0);
  endtask

  task automatic tryIgnored(logic [1:0] k, int cnt);
    int fallsBefore;
    bit sawBusy;
    @(negedge clk);
    while (busy) @(negedge clk);
    fallsBefore = csFalls;
    sawBusy = 1'b0;
    reqValid = 1'b1; reqType = k; reqPage = 13'd5; reqByte = 10'd5; reqCount = 16'(cnt);
    @(negedge clk);
    reqValid = 1'b0;
    repeat (20) begin
      if (busy || !flashCsN) sawBusy = 1'b1;
      @(negedge clk);
    end
    check(!sawBusy && csFalls == fallsBefore, "R9 illegal request ignored", sawBusy, 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    check(flashCsN == 1'b1 && flashSck == 1'b0 && busy == 1'b0 && dataValid == 1'b0,
          "R10 reset state", {flashCsN, flashSck, busy, dataValid}, 4'b1000);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(flashCsN == 1'b1 && flashSck == 1'b0 && busy == 1'b0 && dataValid == 1'b0,
          "R10 idle after reset", {flashCsN, flashSck, busy, dataValid}, 4'b1000);

    // directed corners
    doRead(2'd0, 13'd8191, 10'd527, 3, 1'b0);
    doRead(2'd1, 13'd77, 10'd0, 1, 1'b0);
    doRead(2'd2, 13'd8191, 10'd527, 4, 1'b1);
    readyPct = 30;
    doRead(2'd0, 13'd1234, 10'd265, 6, 1'b1);
    readyPct = 90;
    doRead(2'd1, 13'd0, 10'd520, 600, 1'b0);
    tryIgnored(2'd0, 0);
    tryIgnored(2'd3, 5);

    // constrained random
    for (int t = 0; t < 14; t++) begin
      readyPct = 40 + int'($urandom_range(60));
      doRead(2'($urandom_range(2)), 13'($urandom_range(8191)),
             10'($urandom_range(527)), 1 + int'($urandom_range(12)), t[0]);
    end
    check(minGap >= 4 * HALF, "R6 chip select gap", minGap, 4 * HALF);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule